// File: doc/BRIEF.md
# MSI Coherent L1 Cache Controller

This block is the controller of a blocking, direct-mapped level-one data cache whose line is one word wide. Every line carries an address tag and one of three coherence states: invalid, shared or modified. The processor side takes loads and stores and returns load data. The parent side has an outgoing message channel, for upgrade requests and for responses, and an incoming channel that brings fill responses and downgrade requests from the parent level.

Load hits and store hits complete inside the cache. Any other access starts a miss. The miss writes back a valid victim, asks the parent for the right permission and waits for the fill. It then installs the line and, for a load, returns the data. A store to a shared copy of the same address asks for modified permission directly. Downgrade requests from the parent are served both while the cache is idle and while a miss is in flight. A downgrade that finds nothing to lower is dropped without a reply. A line can also be given up on request through an eviction strobe.

Top module: `msi_l1_cache`

## Requirements
- R1: State codes on upState and dnState are I=0, S=1, M=2. After reset every line is I, procReqReady is high, upValid and procRespValid are low, and the first access to any address misses.
- R2: A load whose index holds a matching tag in S or M raises procRespValid with the stored word in the cycle after acceptance and sends no message.
- R3: A store hits only on a matching line in M and updates the word silently. A store to a matching line in S sends a request (upIsReq=1, upState=M) for its own address with no write-back first. Requests never carry data.
- R4: On any other miss, a victim in S or M is first sent as a response (upIsReq=0) with state I and address {tag, index}. upHasData is set only for a victim in M, and the line becomes I. The miss then requests state S for a load or M for a store. A message leaves only in a cycle with upValid and upReady both high.
- R5: A fill response (dnIsReq=0) is taken while the miss waits for it. The line takes the granted state and the miss tag. It stores the fill word for a load or the pending store word for a store. A load's procRespValid carries the fill word in the cycle after the fill is taken; a store gives no response.
- R6: Processor requests are accepted only when no miss is pending: procReqReady is low from a miss's acceptance through its response cycle. It is also low while a downgrade request waits on the incoming channel.
- R7: A downgrade request (dnIsReq=1) whose address matches a line above the requested state is answered by a response with the requested state and that address. Data is attached only if the line was M, and the line is lowered to the requested state.
- R8: A downgrade request that finds its line at or below the requested state, or a tag mismatch, is dequeued with no outgoing message and leaves the line unchanged.
- R9: While a miss is pending, a downgrade request is served ahead of the miss's own next message, except in the response cycle, when it is not dequeued.
- R10: evictReq, while idle with no processor request, sends a response with state I for the line at evictIdx. Data is attached if the line was M, and the line becomes I. An evict of a line in I sends nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| procReqValid | input | 1 | Processor request present |
| procReqReady | output | 1 | Processor request accepted this cycle |
| procReqIsStore | input | 1 | 1 = store, 0 = load |
| procReqAddr | input | AW | Word address |
| procReqData | input | DW | Store data |
| procRespValid | output | 1 | Load data returned |
| procRespData | output | DW | Load data |
| evictReq | input | 1 | Voluntary eviction strobe |
| evictIdx | input | IW | Line index to evict |
| upValid | output | 1 | Outgoing message valid |
| upReady | input | 1 | Parent takes outgoing message |
| upIsReq | output | 1 | 1 = request, 0 = response |
| upAddr | output | AW | Message address |
| upState | output | 2 | Requested or resulting state |
| upHasData | output | 1 | upData is meaningful |
| upData | output | DW | Written-back word, zero when absent |
| dnValid | input | 1 | Incoming message valid |
| dnReady | output | 1 | Incoming message dequeued |
| dnIsReq | input | 1 | 1 = downgrade request, 0 = fill response |
| dnAddr | input | AW | Message address |
| dnState | input | 2 | Granted or requested state |
| dnData | input | DW | Fill word |

## Verification
The hardest situation to reach is a downgrade that lands in the middle of a miss. It must arrive while the victim write-back is still queued, or while the fill is outstanding, or in the single response cycle when it must wait. The bench reaches these from a task that runs the miss step by step. It offers the downgrade on the incoming channel at the chosen step, including one aimed at the very line being upgraded, so that the shared copy is lost before the modified grant arrives. Random traffic over a small address window keeps victims dirty and tags colliding, so write-backs with and without data occur often.

// File: rtl/msi_l1_pkg.sv
package msi_l1_pkg;
  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_M = 2'd2} lineSt_t;
  typedef enum logic [2:0] {MS_READY, MS_START, MS_FILLREQ, MS_WAIT, MS_RESP} mshr_t;
  typedef enum logic [1:0] {IX_REQ, IX_MISS, IX_DN, IX_EVICT} idxSel_t;
  typedef enum logic [1:0] {D_PROC, D_DN, D_MISS} dSel_t;

  typedef struct packed {
    logic    latchReq;
    logic    hitRsp;
    logic    stWe;
    lineSt_t stVal;
    logic    tagWe;
    logic    dWe;
    dSel_t   dSel;
    idxSel_t idxSel;
    logic    upUseTag;
    logic    sendData;
  } strobe_t;
endpackage

// File: rtl/msi_l1_dpath.sv
module msi_l1_dpath
  import msi_l1_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       stb,
  input  logic [AW-1:0] procReqAddr,
  input  logic          procReqIsStore,
  input  logic [DW-1:0] procReqData,
  input  logic [AW-1:0] dnAddr,
  input  logic [DW-1:0] dnData,
  input  lineSt_t       dnSt,
  input  logic [IW-1:0] evictIdx,
  output lineSt_t       reqLineSt,
  output lineSt_t       missLineSt,
  output lineSt_t       dnLineSt,
  output lineSt_t       evLineSt,
  output logic          missIsStore,
  output logic [AW-1:0] upAddr,
  output logic [DW-1:0] upData,
  output logic          hitRspQ,
  output logic [DW-1:0] procRespData
);
  localparam int SETS = 1 << IW;
  localparam int TW   = AW - IW;

  lineSt_t       stArr  [SETS];
  logic [TW-1:0] tagArr [SETS];
  logic [DW-1:0] datArr [SETS];

  logic [AW-1:0] missAddr;
  logic [DW-1:0] missData;
  logic [DW-1:0] hitDataQ;
  logic [IW-1:0] reqIx, missIx, dnIx, selIx;

  assign reqIx  = procReqAddr[IW-1:0];
  assign missIx = missAddr[IW-1:0];
  assign dnIx   = dnAddr[IW-1:0];

  always_comb begin
    case (stb.idxSel)
      IX_REQ:  selIx = reqIx;
      IX_MISS: selIx = missIx;
      IX_DN:   selIx = dnIx;
      default: selIx = evictIdx;
    endcase
  end

  // lookups: a tag mismatch reads as invalid
  assign reqLineSt  = (tagArr[reqIx] == procReqAddr[AW-1:IW]) ? stArr[reqIx] : ST_I;
  assign dnLineSt   = (tagArr[dnIx] == dnAddr[AW-1:IW]) ? stArr[dnIx] : ST_I;
  assign missLineSt = stArr[missIx];
  assign evLineSt   = stArr[evictIdx];

  assign upAddr = stb.upUseTag ? {tagArr[selIx], selIx}
                : (stb.idxSel == IX_DN) ? dnAddr : missAddr;
  assign upData = stb.sendData ? datArr[selIx] : '0;

  assign procRespData = hitRspQ ? hitDataQ : datArr[missIx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < SETS; i++) begin
        stArr[i]  <= ST_I;
        tagArr[i] <= '0;
        datArr[i] <= '0;
      end
      missAddr    <= '0;
      missData    <= '0;
      missIsStore <= 1'b0;
      hitRspQ     <= 1'b0;
      hitDataQ    <= '0;
    end else begin
      if (stb.latchReq) begin
        missAddr    <= procReqAddr;
        missData    <= procReqData;
        missIsStore <= procReqIsStore;
      end
      if (stb.stWe)  stArr[selIx]  <= stb.stVal;
      if (stb.tagWe) tagArr[selIx] <= missAddr[AW-1:IW];
      if (stb.dWe) begin
        case (stb.dSel)
          D_PROC:  datArr[selIx] <= procReqData;
          D_DN:    datArr[selIx] <= dnData;
          default: datArr[selIx] <= missData;
        endcase
      end
      hitRspQ  <= stb.hitRsp;
      hitDataQ <= datArr[reqIx];
    end
  end

  // dnSt is consumed by the control; kept here for a uniform interface
  logic unusedSt;
  assign unusedSt = ^dnSt;
endmodule

// File: rtl/msi_l1_ctrl.sv
module msi_l1_ctrl
  import msi_l1_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    procReqValid,
  input  logic    procReqIsStore,
  input  logic    evictReq,
  input  logic    upReady,
  input  logic    dnValid,
  input  logic    dnIsReq,
  input  lineSt_t dnSt,
  input  lineSt_t reqLineSt,
  input  lineSt_t missLineSt,
  input  lineSt_t dnLineSt,
  input  lineSt_t evLineSt,
  input  logic    missIsStore,
  output strobe_t stb,
  output logic    procReqReady,
  output logic    upValid,
  output logic    upIsReq,
  output lineSt_t upState,
  output logic    dnReady,
  output logic    respMiss
);
  mshr_t mshr, nxt;
  logic  dngNow;

  assign dngNow   = dnValid && dnIsReq && (mshr != MS_RESP);
  assign respMiss = (mshr == MS_RESP) && !missIsStore;

  always_comb begin
    stb          = '0;
    nxt          = mshr;
    procReqReady = 1'b0;
    upValid      = 1'b0;
    upIsReq      = 1'b0;
    upState      = ST_I;
    dnReady      = 1'b0;
    if (dngNow) begin
      stb.idxSel = IX_DN;
      if (dnLineSt > dnSt) begin
        upValid      = 1'b1;
        upState      = dnSt;
        stb.sendData = (dnLineSt == ST_M);
        if (upReady) begin
          dnReady   = 1'b1;
          stb.stWe  = 1'b1;
          stb.stVal = dnSt;
        end
      end else begin
        dnReady = 1'b1;
      end
    end else begin
      case (mshr)
        MS_READY: begin
          procReqReady = 1'b1;
          if (procReqValid) begin
            stb.latchReq = 1'b1;
            stb.idxSel   = IX_REQ;
            if (!procReqIsStore && reqLineSt != ST_I) begin
              stb.hitRsp = 1'b1;
            end else if (procReqIsStore && reqLineSt == ST_M) begin
              stb.dWe  = 1'b1;
              stb.dSel = D_PROC;
            end else if (procReqIsStore && reqLineSt == ST_S) begin
              nxt = MS_FILLREQ;
            end else begin
              nxt = MS_START;
            end
          end else if (evictReq && evLineSt != ST_I) begin
            stb.idxSel   = IX_EVICT;
            stb.upUseTag = 1'b1;
            stb.sendData = (evLineSt == ST_M);
            upValid      = 1'b1;
            if (upReady) begin
              stb.stWe  = 1'b1;
              stb.stVal = ST_I;
            end
          end
        end
        MS_START: begin
          stb.idxSel = IX_MISS;
          if (missLineSt != ST_I) begin
            stb.upUseTag = 1'b1;
            stb.sendData = (missLineSt == ST_M);
            upValid      = 1'b1;
            if (upReady) begin
              stb.stWe  = 1'b1;
              stb.stVal = ST_I;
              nxt       = MS_FILLREQ;
            end
          end else begin
            nxt = MS_FILLREQ;
          end
        end
        MS_FILLREQ: begin
          stb.idxSel = IX_MISS;
          upValid    = 1'b1;
          upIsReq    = 1'b1;
          upState    = missIsStore ? ST_M : ST_S;
          if (upReady) nxt = MS_WAIT;
        end
        MS_WAIT: begin
          if (dnValid && !dnIsReq) begin
            dnReady    = 1'b1;
            stb.idxSel = IX_MISS;
            stb.stWe   = 1'b1;
            stb.stVal  = dnSt;
            stb.tagWe  = 1'b1;
            stb.dWe    = 1'b1;
            stb.dSel   = missIsStore ? D_MISS : D_DN;
            nxt        = MS_RESP;
          end
        end
        MS_RESP:  nxt = MS_READY;
        default:  nxt = MS_READY;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) mshr <= MS_READY;
    else       mshr <= nxt;
  end
endmodule

// File: rtl/msi_l1_cache.sv
module msi_l1_cache
  import msi_l1_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          procReqValid,
  output logic          procReqReady,
  input  logic          procReqIsStore,
  input  logic [AW-1:0] procReqAddr,
  input  logic [DW-1:0] procReqData,
  output logic          procRespValid,
  output logic [DW-1:0] procRespData,
  input  logic          evictReq,
  input  logic [IW-1:0] evictIdx,
  output logic          upValid,
  input  logic          upReady,
  output logic          upIsReq,
  output logic [AW-1:0] upAddr,
  output logic [1:0]    upState,
  output logic          upHasData,
  output logic [DW-1:0] upData,
  input  logic          dnValid,
  output logic          dnReady,
  input  logic          dnIsReq,
  input  logic [AW-1:0] dnAddr,
  input  logic [1:0]    dnState,
  input  logic [DW-1:0] dnData
);
  strobe_t stb;
  lineSt_t dnSt, reqLineSt, missLineSt, dnLineSt, evLineSt, upStateE;
  logic    missIsStore, hitRspQ, respMiss;

  assign dnSt          = lineSt_t'(dnState);
  assign upState       = upStateE;
  assign upHasData     = stb.sendData;
  assign procRespValid = hitRspQ || respMiss;

  msi_l1_ctrl ctrl (
    .clk, .rstN, .procReqValid, .procReqIsStore, .evictReq, .upReady,
    .dnValid, .dnIsReq, .dnSt, .reqLineSt, .missLineSt, .dnLineSt, .evLineSt,
    .missIsStore, .stb, .procReqReady, .upValid, .upIsReq,
    .upState(upStateE), .dnReady, .respMiss
  );

  msi_l1_dpath #(.AW(AW), .DW(DW), .IW(IW)) dpath (
    .clk, .rstN, .stb, .procReqAddr, .procReqIsStore, .procReqData,
    .dnAddr, .dnData, .dnSt, .evictIdx, .reqLineSt, .missLineSt, .dnLineSt,
    .evLineSt, .missIsStore, .upAddr, .upData, .hitRspQ, .procRespData
  );
endmodule

// File: rtl/msi_l1_chk.sv
module msi_l1_chk (
  input logic       clk,
  input logic       rstN,
  input logic       procReqValid,
  input logic       procReqReady,
  input logic       procReqIsStore,
  input logic       procRespValid,
  input logic       upValid,
  input logic       upIsReq,
  input logic [1:0] upState,
  input logic       upHasData,
  input logic       dnValid,
  input logic       dnReady,
  input logic       dnIsReq
);
  logic lastStore;
  logic fillTaken;

  assign fillTaken = dnValid && dnReady && !dnIsReq;

  always_ff @(posedge clk) begin
    if (!rstN) lastStore <= 1'b0;
    else if (procReqValid && procReqReady) lastStore <= procReqIsStore;
  end

  assert_req_no_data_R3: assert property (@(posedge clk) disable iff (!rstN)
    upValid && upIsReq |-> !upHasData);

  assert_req_not_invalid_R4: assert property (@(posedge clk) disable iff (!rstN)
    upValid && upIsReq |-> upState != 2'd0);

  assert_reply_never_m_R7: assert property (@(posedge clk) disable iff (!rstN)
    upValid && !upIsReq |-> upState != 2'd2);

  assert_load_data_after_fill_R5: assert property (@(posedge clk) disable iff (!rstN)
    fillTaken && !lastStore |=> procRespValid);

  assert_busy_after_fill_R6: assert property (@(posedge clk) disable iff (!rstN)
    fillTaken |=> !procReqReady);

  assert_no_dng_in_resp_R9: assert property (@(posedge clk) disable iff (!rstN)
    fillTaken |=> !(dnValid && dnIsReq && dnReady));
endmodule

bind msi_l1_cache msi_l1_chk chkInst (
  .clk(clk), .rstN(rstN), .procReqValid(procReqValid), .procReqReady(procReqReady),
  .procReqIsStore(procReqIsStore), .procRespValid(procRespValid), .upValid(upValid),
  .upIsReq(upIsReq), .upState(upState), .upHasData(upHasData), .dnValid(dnValid),
  .dnReady(dnReady), .dnIsReq(dnIsReq)
);

// File: tb/msi_l1_cache_test.sv
`timescale 1ns/1ps
module msi_l1_cache_test;
  localparam int AW = 8, DW = 32, IW = 2, SETS = 4, TW = AW - IW;

  logic clk = 0, rstN = 0;
  logic procReqValid = 0, procReqIsStore = 0;
  logic [AW-1:0] procReqAddr = '0;
  logic [DW-1:0] procReqData = '0;
  logic procReqReady, procRespValid;
  logic [DW-1:0] procRespData;
  logic evictReq = 0;
  logic [IW-1:0] evictIdx = '0;
  logic upValid, upIsReq, upHasData;
  logic upReady = 0;
  logic [AW-1:0] upAddr;
  logic [1:0] upState;
  logic [DW-1:0] upData;
  logic dnValid = 0, dnIsReq = 0;
  logic dnReady;
  logic [AW-1:0] dnAddr = '0;
  logic [1:0] dnState = '0;
  logic [DW-1:0] dnData = '0;

  always #4 clk = ~clk;

  msi_l1_cache #(.AW(AW), .DW(DW), .IW(IW)) uut (
    .clk, .rstN, .procReqValid, .procReqReady, .procReqIsStore, .procReqAddr,
    .procReqData, .procRespValid, .procRespData, .evictReq, .evictIdx,
    .upValid, .upReady, .upIsReq, .upAddr, .upState, .upHasData, .upData,
    .dnValid, .dnReady, .dnIsReq, .dnAddr, .dnState, .dnData
  );

  int nChk = 0, nBad = 0;
  bit done = 0;

  // expected line contents, kept from the requirements
  logic [1:0]    mSt  [SETS];
  logic [TW-1:0] mTag [SETS];
  logic [DW-1:0] mData[SETS];

  task automatic chk(bit ok, string rq, logic [63:0] act, logic [63:0] exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic waitUp(output logic r, output logic [AW-1:0] a, output logic [1:0] s,
                        output logic hd, output logic [DW-1:0] d);
    bit got = 0;
    r = 0; a = '0; s = '0; hd = 0; d = '0;
    for (int n = 0; n < 40 && !got; n++) begin
      upReady = ($urandom % 4) != 0;
      #1;
      if (upValid && upReady) begin
        r = upIsReq; a = upAddr; s = upState; hd = upHasData; d = upData; got = 1;
      end
      @(negedge clk);
    end
    upReady = 0;
    if (!got) chk(0, "R4 outgoing message missing", 0, 1);
  endtask

  task automatic sendDng(bit waitEdge, logic [AW-1:0] a, logic [1:0] t);
    logic [IW-1:0] ix = a[IW-1:0];
    logic [1:0] cur = (mTag[ix] == a[AW-1:IW]) ? mSt[ix] : 2'd0;
    if (waitEdge) @(negedge clk);
    dnValid = 1; dnIsReq = 1; dnAddr = a; dnState = t; dnData = '0; upReady = 1;
    #1;
    if (cur > t) begin
      chk(upValid && !upIsReq && upAddr == a && upState == t, "R7 downgrade reply",
          {upValid, upIsReq, upAddr, upState}, {2'b10, a, t});
      chk(upHasData == (cur == 2'd2), "R7 reply data flag", upHasData, cur == 2'd2);
      if (cur == 2'd2) chk(upData == mData[ix], "R7 reply data", upData, mData[ix]);
      chk(dnReady, "R7 request dequeued", dnReady, 1);
      mSt[ix] = t;
    end else begin
      chk(dnReady && !upValid, "R8 downgrade dropped silently", {dnReady, upValid}, 2'b10);
    end
    @(negedge clk);
    dnValid = 0; dnIsReq = 0; upReady = 0;
    #1;
  endtask

  task automatic doEvict(logic [IW-1:0] ix);
    @(negedge clk);
    evictReq = 1; evictIdx = ix; upReady = 1;
    #1;
    if (mSt[ix] != 0) begin
      chk(upValid && !upIsReq && upState == 0 && upAddr == {mTag[ix], ix}, "R10 eviction message",
          {upValid, upIsReq, upState, upAddr}, {2'b10, 2'b00, mTag[ix], ix});
      chk(upHasData == (mSt[ix] == 2), "R10 eviction data flag", upHasData, mSt[ix] == 2);
      if (mSt[ix] == 2) chk(upData == mData[ix], "R10 eviction data", upData, mData[ix]);
      mSt[ix] = 0;
    end else begin
      chk(!upValid, "R10 evict of invalid line silent", upValid, 0);
    end
    @(negedge clk);
    evictReq = 0; upReady = 0;
  endtask

  task automatic doAccess(bit st, logic [AW-1:0] a, logic [DW-1:0] d, bit grantM,
                          int dngWhen, logic [AW-1:0] dA, logic [1:0] dT, bit poke);
    logic [IW-1:0] ix = a[IW-1:0];
    logic [TW-1:0] tg = a[AW-1:IW];
    logic [TW-1:0] tg2 = tg + 1'b1;
    bit hitAny = (mSt[ix] != 0) && (mTag[ix] == tg);
    logic r, hd;
    logic [AW-1:0] ra;
    logic [1:0] rs, g;
    logic [DW-1:0] rd, fillD;
    int n = 0;
    @(negedge clk);
    procReqValid = 1; procReqIsStore = st; procReqAddr = a; procReqData = d;
    #1;
    while (!procReqReady && n < 50) begin @(negedge clk); #1; n++; end
    @(negedge clk);
    procReqValid = 0;
    #1;
    if (!st && hitAny) begin
      chk(procRespValid && procRespData == mData[ix], "R2 load hit data",
          {procRespValid, procRespData}, {1'b1, mData[ix]});
      chk(!upValid, "R2 hit sends no message", upValid, 0);
      return;
    end
    if (st && hitAny && mSt[ix] == 2) begin
      chk(!procRespValid && !upValid, "R3 store hit silent", {procRespValid, upValid}, 0);
      mData[ix] = d;
      return;
    end
    if (!(st && hitAny)) begin
      if (dngWhen == 1) sendDng(0, dA, dT);
      if (mSt[ix] != 0) begin
        waitUp(r, ra, rs, hd, rd);
        chk(!r && ra == {mTag[ix], ix} && rs == 0, "R4 victim write-back",
            {r, ra, rs}, {1'b0, mTag[ix], ix, 2'b00});
        chk(hd == (mSt[ix] == 2), "R4 write-back data flag", hd, mSt[ix] == 2);
        if (mSt[ix] == 2) chk(rd == mData[ix], "R4 write-back data", rd, mData[ix]);
        mSt[ix] = 0;
      end
    end
    waitUp(r, ra, rs, hd, rd);
    chk(r && ra == a && rs == (st ? 2'd2 : 2'd1) && !hd, st ? "R3 request for M" : "R4 request for S",
        {r, ra, rs, hd}, {1'b1, a, st ? 2'd2 : 2'd1, 1'b0});
    if (dngWhen == 2) sendDng(1, dA, dT);
    g = (st || grantM) ? 2'd2 : 2'd1;
    fillD = $urandom;
    @(negedge clk);
    dnValid = 1; dnIsReq = 0; dnAddr = a; dnState = g; dnData = fillD;
    #1;
    chk(dnReady, "R5 fill accepted", dnReady, 1);
    @(negedge clk);
    dnValid = 0;
    #1;
    mSt[ix] = g; mTag[ix] = tg; mData[ix] = st ? d : fillD;
    if (!st) chk(procRespValid && procRespData == fillD, "R5 load data after fill",
                 {procRespValid, procRespData}, {1'b1, fillD});
    else     chk(!procRespValid, "R5 store gives no response", procRespValid, 0);
    chk(!procReqReady, "R6 not ready in response cycle", procReqReady, 0);
    if (poke) begin
      dnValid = 1; dnIsReq = 1; dnAddr = {tg2, ix}; dnState = 2'd0;
      #1;
      chk(!dnReady, "R9 downgrade held in response cycle", dnReady, 0);
      @(negedge clk);
      #1;
      chk(dnReady && !upValid && !procReqReady, "R8 mismatched downgrade dropped",
          {dnReady, upValid, procReqReady}, 3'b100);
      @(negedge clk);
      dnValid = 0; dnIsReq = 0;
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog (all requirements): actual 0 expected 1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < SETS; i++) begin mSt[i] = 0; mTag[i] = '0; mData[i] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    #1;
    chk(procReqReady && !upValid && !procRespValid && !dnReady, "R1 reset state",
        {procReqReady, upValid, procRespValid, dnReady}, 4'b1000);

    // R1: cold miss, then R2 hit
    doAccess(0, 8'h00, '0, 0, 0, '0, 0, 0);
    doAccess(0, 8'h00, '0, 0, 0, '0, 0, 0);
    // R3: upgrade from S, then read back
    doAccess(1, 8'h00, 32'hCAFE0001, 1, 0, '0, 0, 0);
    doAccess(0, 8'h00, '0, 0, 0, '0, 0, 0);
    doAccess(1, 8'h00, 32'hCAFE0002, 1, 0, '0, 0, 0);
    // R4: dirty victim written back
    doAccess(1, 8'h04, 32'hBEEF0004, 1, 0, '0, 0, 0);
    doAccess(1, 8'h05, 32'hBEEF0005, 1, 0, '0, 0, 0);
    // R9: downgrade arrives while write-back pending
    doAccess(0, 8'h08, '0, 0, 1, 8'h05, 2'd1, 0);
    // R9: stale upgrade, line lost while waiting, plus response-cycle hold
    doAccess(0, 8'h10, '0, 0, 0, '0, 0, 0);
    doAccess(1, 8'h10, 32'h5A5A0010, 1, 2, 8'h10, 2'd0, 1);
    doAccess(0, 8'h10, '0, 0, 0, '0, 0, 0);
    // R7 / R8 directed downgrades
    sendDng(1, 8'h10, 2'd1);
    sendDng(1, 8'h10, 2'd1);
    sendDng(1, 8'h10, 2'd0);
    sendDng(1, 8'h10, 2'd0);
    // R10 evictions
    doEvict(2'd1);
    doEvict(2'd1);
    doAccess(1, 8'h06, 32'h00000666, 1, 0, '0, 0, 0);
    doEvict(2'd2);

    for (int k = 0; k < 400; k++) begin
      int op = $urandom % 10;
      logic [AW-1:0] a = AW'($urandom % 16);
      logic [AW-1:0] dA = AW'($urandom % 16);
      if (op < 4)
        doAccess(0, a, '0, $urandom % 2, $urandom % 3, dA, 2'($urandom % 2), ($urandom % 4) == 0);
      else if (op < 7)
        doAccess(1, a, $urandom, 1, $urandom % 3, dA, 2'($urandom % 2), ($urandom % 4) == 0);
      else if (op < 9)
        sendDng(1, a, 2'($urandom % 2));
      else
        doEvict(IW'($urandom % SETS));
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule